// File: doc/BRIEF.md
# Frame Interrupt Controller

This block turns frame events from a display timing generator into one level-sensitive interrupt line. The timing generator supplies one-cycle strobes: start of back porch, start of vertical sync and start of active video. A two-bit selector in the control register chooses which of these strobes counts as the frame event. It can also choose none of them.

A selected strobe sets a frame pending bit. That bit lives in a separate pending register, and software clears it by writing one to it. The interrupt line is driven high only while the pending bit is set and both the global enable and the frame enable are on. Software reaches both registers through a small synchronous read/write port. A read returns its data one cycle after the read strobe.

Top module: `frame_irq_ctrl`

## Requirements
- R1: Register offset 0 is control. Bit 0 is the global enable, bit 1 is the frame enable and bits 3:2 are the frame selector. Other bits are dropped on write and read as 0. A read strobe returns the addressed register on `reg_rdata` one cycle later.
- R2: Selector code 0 picks `tg_evt[0]` (back-porch start), code 1 picks `tg_evt[1]` (vsync start), code 2 picks `tg_evt[2]` (active start) and code 3 picks no event. Strobes on lines that are not selected do not set the pending bit.
- R3: A cycle in which the selected strobe is high sets the frame pending bit, which is bit 0 of offset 1. This happens whatever the enables are.
- R4: `irq` is registered and goes high one cycle after the pending bit, the global enable and the frame enable are all set. It stays high while they stay set and drops one cycle after any of them clears. With either enable off, no further interrupt is raised.
- R5: Writing 1 to bit 0 of offset 1 clears the pending bit. Writing 0 to it leaves the bit unchanged.
- R6: If the selected strobe arrives in the same cycle as a clearing write, the pending bit stays set.
- R7: Synchronous reset clears both enables, the selector, the pending bit, `irq` and `reg_rdata`.
- R8: Writes to offsets 2 and 3 are ignored, and reads from them return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register offset |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, valid the cycle after `reg_rd` |
| tg_evt | input | 3 | Timing strobes: back-porch, vsync, active start |
| irq | output | 1 | Frame interrupt level |

## Verification
The main function is driven with three strobe patterns:
- A strobe on the selected line only.
- Strobes on lines that are not selected.
- All lines at once while the selector is set to "none".

Together these show that capture follows the selector and not just any activity. Enables are then switched one at a time while a bit is pending, which separates the AND gating from plain pending capture. Clearing writes are tried with a 0 and with a 1, and once in the same cycle as a strobe, which separates the clear path from event priority. Unmapped offsets are written and read to show that they leave the real registers untouched.

// File: rtl/frame_irq_pkg.sv
package frame_irq_pkg;
  localparam int SEL_W   = 2;
  localparam int NUM_EVT = 3;
  localparam logic [SEL_W-1:0] SEL_NONE = '1;

  localparam int OFS_CTRL = 0;
  localparam int OFS_PEND = 1;
  localparam int CTRL_W   = SEL_W + 2;

  typedef struct packed {
    logic [SEL_W-1:0] sel;
    logic             frame_en;
    logic             glob_en;
  } ctrl_t;
endpackage

// File: rtl/frame_irq_regs.sv
module frame_irq_regs
  import frame_irq_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              pend,
  output ctrl_t             ctrl,
  output logic              clr_req,
  output logic [DATA_W-1:0] reg_rdata
);
  logic sel_ctrl, sel_pend;

  assign sel_ctrl = (reg_addr == ADDR_W'(OFS_CTRL));
  assign sel_pend = (reg_addr == ADDR_W'(OFS_PEND));
  assign clr_req  = reg_wr && sel_pend && reg_wdata[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '0;
    end else if (reg_wr && sel_ctrl) begin
      ctrl <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      if (sel_ctrl)      reg_rdata <= DATA_W'(ctrl);
      else if (sel_pend) reg_rdata <= DATA_W'(pend);
      else               reg_rdata <= '0;
    end else begin
      reg_rdata <= '0;
    end
  end
endmodule

// File: rtl/frame_irq_evsel.sv
module frame_irq_evsel
  import frame_irq_pkg::*;
(
  input  logic [SEL_W-1:0]   sel,
  input  logic [NUM_EVT-1:0] evt,
  output logic               hit
);
  logic [NUM_EVT-1:0] match;

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_match
    assign match[i] = (sel == SEL_W'(i)) && evt[i];
  end

  assign hit = |match;
endmodule

// File: rtl/frame_irq_pend.sv
module frame_irq_pend (
  input  logic clk,
  input  logic rst,
  input  logic hit,
  input  logic clr,
  input  logic glob_en,
  input  logic frame_en,
  output logic pend,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= 1'b0;
      irq  <= 1'b0;
    end else begin
      pend <= hit || (pend && !clr);
      irq  <= pend && glob_en && frame_en;
    end
  end
endmodule

// File: rtl/frame_irq_ctrl.sv
module frame_irq_ctrl
  import frame_irq_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  input  logic [NUM_EVT-1:0] tg_evt,
  output logic               irq
);
  ctrl_t ctrl_q;
  logic  pend_q, clr_w, hit_w;

  frame_irq_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .pend(pend_q),
    .ctrl(ctrl_q), .clr_req(clr_w), .reg_rdata(reg_rdata)
  );

  frame_irq_evsel u_evsel (
    .sel(ctrl_q.sel), .evt(tg_evt), .hit(hit_w)
  );

  frame_irq_pend u_pend (
    .clk(clk), .rst(rst), .hit(hit_w), .clr(clr_w),
    .glob_en(ctrl_q.glob_en), .frame_en(ctrl_q.frame_en),
    .pend(pend_q), .irq(irq)
  );
endmodule

// File: rtl/frame_irq_ctrl_chk.sv
module frame_irq_ctrl_chk
  import frame_irq_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 32
) (
  input logic               clk,
  input logic               rst,
  input logic               reg_wr,
  input logic [ADDR_W-1:0]  reg_addr,
  input logic [DATA_W-1:0]  reg_wdata,
  input logic [NUM_EVT-1:0] tg_evt,
  input ctrl_t              ctrl,
  input logic               pend,
  input logic               irq
);
  logic sel_evt, wr_one, wr_zero;

  always_comb begin
    unique case (ctrl.sel)
      2'd0:    sel_evt = tg_evt[0];
      2'd1:    sel_evt = tg_evt[1];
      2'd2:    sel_evt = tg_evt[2];
      default: sel_evt = 1'b0;
    endcase
  end

  assign wr_one  = reg_wr && (reg_addr == ADDR_W'(OFS_PEND)) && reg_wdata[0];
  assign wr_zero = reg_wr && (reg_addr == ADDR_W'(OFS_PEND)) && !reg_wdata[0];

  assert_irq_gated_R4: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(pend && ctrl.glob_en && ctrl.frame_en));

  assert_irq_follows_R4: assert property (@(posedge clk) disable iff (rst)
    (pend && ctrl.glob_en && ctrl.frame_en) |=> irq);

  assert_set_by_selected_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(pend) |-> $past(sel_evt));

  assert_none_code_R2: assert property (@(posedge clk) disable iff (rst)
    (ctrl.sel == SEL_NONE && !pend) |=> !pend);

  assert_zero_keeps_R5: assert property (@(posedge clk) disable iff (rst)
    (pend && wr_zero) |=> pend);

  assert_one_clears_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_one && !sel_evt) |=> !pend);

  assert_event_wins_R6: assert property (@(posedge clk) disable iff (rst)
    sel_evt |=> pend);
endmodule

bind frame_irq_ctrl frame_irq_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .tg_evt(tg_evt), .ctrl(ctrl_q),
  .pend(pend_q), .irq(irq)
);

// File: tb/frame_irq_ctrl_test.sv
module frame_irq_ctrl_test;
  localparam int ADDR_W = 2;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              reg_wr = 1'b0;
  logic              reg_rd = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [DATA_W-1:0] reg_wdata = '0;
  logic [DATA_W-1:0] reg_rdata;
  logic [2:0]        tg_evt = '0;
  logic              irq;

  frame_irq_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tg_evt(tg_evt), .irq(irq)
  );

  always #5 clk = ~clk;

  typedef struct {
    int          cyc;
    bit          is_rd;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int cyc_cnt = 0;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always @(posedge clk) cyc_cnt <= cyc_cnt + 1;

  // monitor: compares due items a little after each falling edge
  always begin
    @(negedge clk);
    #1;
    while (q.size() > 0 && q[0].cyc <= cyc_cnt) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      act = it.is_rd ? reg_rdata : {31'd0, irq};
      n_chk++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s: %s actual %h expected %h", it.tag,
                 it.is_rd ? "rdata" : "irq", act, it.exp);
      end
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = ADDR_W'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input int a, input logic [31:0] e, input string tag);
    item_t it;
    reg_rd = 1'b1; reg_addr = ADDR_W'(a);
    it.cyc = cyc_cnt + 1; it.is_rd = 1'b1; it.exp = e; it.tag = tag;
    q.push_back(it);
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic pulse(input logic [2:0] e);
    tg_evt = e;
    @(negedge clk);
    tg_evt = '0;
  endtask

  task automatic exp_irq(input logic v, input string tag);
    item_t it;
    it.cyc = cyc_cnt; it.is_rd = 1'b0; it.exp = {31'd0, v}; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    idle(3);
    rst = 1'b0;
    // R7: reset state
    exp_irq(1'b0, "R7");
    rd(0, 32'h0, "R7");
    rd(1, 32'h0, "R7");
    // R1: control layout, upper bits dropped
    wr(0, 32'hFFFF_FFF7);
    rd(0, 32'h7, "R1");
    // R3/R4: vsync strobe with selector code 1
    pulse(3'b010);
    exp_irq(1'b0, "R4");
    rd(1, 32'h1, "R3");
    exp_irq(1'b1, "R4");
    // R5: writing 0 keeps, writing 1 clears
    wr(1, 32'h0);
    rd(1, 32'h1, "R5");
    exp_irq(1'b1, "R5");
    wr(1, 32'h1);
    idle(1);
    exp_irq(1'b0, "R5");
    rd(1, 32'h0, "R5");
    // R2: lines that are not selected
    pulse(3'b101);
    rd(1, 32'h0, "R2");
    // R2: code 3 selects nothing
    wr(0, 32'hF);
    pulse(3'b111);
    rd(1, 32'h0, "R2");
    idle(1);
    exp_irq(1'b0, "R2");
    // R2: code 0 selects back-porch strobe
    wr(0, 32'h3);
    pulse(3'b001);
    rd(1, 32'h1, "R2");
    exp_irq(1'b1, "R2");
    wr(1, 32'h1);
    // R3/R4: frame enable off, still recorded, no irq
    wr(0, 32'h5);
    pulse(3'b010);
    rd(1, 32'h1, "R3");
    idle(1);
    exp_irq(1'b0, "R4");
    wr(0, 32'h7);
    idle(1);
    exp_irq(1'b1, "R4");
    wr(0, 32'h6);
    idle(1);
    exp_irq(1'b0, "R4");
    // R4: both enables off, new event raises nothing
    wr(0, 32'h4);
    wr(1, 32'h1);
    pulse(3'b010);
    idle(2);
    exp_irq(1'b0, "R4");
    rd(1, 32'h1, "R3");
    // R6: event and clear in the same cycle
    wr(0, 32'h7);
    reg_wr = 1'b1; reg_addr = ADDR_W'(1); reg_wdata = 32'h1; tg_evt = 3'b010;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0; tg_evt = '0;
    rd(1, 32'h1, "R6");
    // R8: unmapped offsets
    wr(2, 32'hFFFF_FFFF);
    wr(3, 32'h0);
    rd(2, 32'h0, "R8");
    rd(3, 32'h0, "R8");
    rd(0, 32'h7, "R8");
    rd(1, 32'h1, "R8");
    idle(3);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule